// File: doc/BRIEF.md
# Host-to-Shared-RAM Write Arbiter

This block sits between an asynchronous host processor and an external RAM that several on-chip engines also read. It takes the host's active-low chip-select and write strobe and samples them with the system clock. It recognises a host write only when two clock edges in a row both see the strobes asserted. One edge later it samples the top address bit, which picks the target. When that bit is set, the write goes to an on-chip command register. When it is clear, the write goes to the RAM.

A RAM write from the host takes two cycles. In the first cycle chip-select is driven low and the address and data are presented. In the second cycle write-enable also goes low. Internal engines always win the memory. A host RAM write is thrown away, and a one-cycle drop pulse is raised, in three cases: an engine is requesting the memory when the write would start, the holdoff counter left by the previous host RAM write is still running, or a host write is already under way. The block also drives the enables for an external address buffer and a bidirectional data latch.

Top module: `hostram_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, ram_cs_n and ram_we_n are 1, ram_data_oe, abuf_en, dlat_en, dlat_dir, cmd_wr and wr_drop are 0, and cmd_reg is 0.
- R2: The host strobes count as asserted when host_cs_n and host_wr_n are both 0. An assertion that only one rising clock edge sees produces no register write, no RAM cycle and no drop pulse.
- R3: If host_addr bit 17 is 1 at the third rising edge of an access, then after that edge cmd_reg takes host_data and cmd_wr is 1 for exactly one cycle. No RAM strobe moves, even if engines are requesting the memory.
- R4: If host_addr bit 17 is 0 at the third edge and nothing blocks the write, then the write runs in two cycles. In the cycle after that edge, ram_cs_n is 0 and ram_we_n is 1. In the next cycle both are 0. ram_addr holds host_addr bits 16:0 and ram_data holds host_data for both cycles. After that both strobes return to 1.
- R5: If any int_req bit is 1 at the third edge of a host RAM write, the write is not performed, and wr_drop is 1 for exactly one cycle.
- R6: After a host RAM write ends, a counter starts from holdoff_cfg and counts down by one each cycle. A host RAM write whose third edge finds the counter above zero is dropped as in R5. If a second access starts one cycle after the first is released, it is dropped when holdoff_cfg is 4 and performed when holdoff_cfg is 3.
- R7: int_gnt is the lowest-numbered set bit of int_req (bit 0 has the highest priority), is all zero while a host RAM write is in progress, and is never more than one-hot.
- R8: abuf_en and dlat_en are 1 while an access is being qualified (after the first edge that sees the strobes, until the decision) and during both RAM write cycles. ram_data_oe and dlat_dir (1 = drive toward the RAM) are 1 only during the two RAM write cycles.
- R9: One continuous assertion of the strobes produces exactly one access, however long the host holds the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip-select, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | 18 | Host address; bit 17 selects the command register |
| host_data | input | 16 | Host write data |
| int_req | input | 3 | Internal engine memory requests, bit 0 highest priority |
| holdoff_cfg | input | 6 | Holdoff length in cycles after a host RAM write |
| int_gnt | output | 3 | One-hot grant to internal engines |
| ram_cs_n | output | 1 | RAM chip-select, active low |
| ram_we_n | output | 1 | RAM write-enable, active low |
| ram_addr | output | 17 | RAM address for host writes |
| ram_data | output | 16 | RAM write data for host writes |
| ram_data_oe | output | 1 | Drive enable for the RAM data bus |
| abuf_en | output | 1 | External address buffer enable |
| dlat_en | output | 1 | External data latch enable |
| dlat_dir | output | 1 | Data latch direction, 1 = toward RAM |
| cmd_reg | output | 16 | Command register contents |
| cmd_wr | output | 1 | One-cycle pulse on a command register write |
| wr_drop | output | 1 | One-cycle pulse when a host RAM write is refused |

## Verification
Take the rising edge at which the strobes are first seen as edge 1. The buffer and latch enables come up after edge 1. After edge 3, the outcome appears: the command pulse, the drop pulse or the first RAM cycle. Write-enable falls after edge 4, and both strobes rise again after edge 5. The bench drives every input on a falling edge and then steps from falling edge to falling edge. It reads each result in the half-cycle that follows the rising edge where that result becomes due, so every check looks at a settled value. The holdoff boundary is set by the counter value seen at edge 3 of the second access, so the bench starts that access one cycle after releasing the first and compares a length of 4 against a length of 3.

// File: rtl/hra_pkg.sv
package hra_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2
    } wr_phase_e;

    function automatic logic in_ram_cycle(input wr_phase_e ph);
        return (ph == PH_SETUP) || (ph == PH_STROBE);
    endfunction

endpackage

// File: rtl/hra_sync.sv
module hra_sync (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    output logic detect,
    output logic qualifying
);
    logic raw, smp_a, smp_b, taken;

    assign raw        = ~cs_n & ~wr_n;
    assign detect     = smp_a & smp_b & ~taken;
    assign qualifying = smp_a & ~taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_a <= 1'b0;
            smp_b <= 1'b0;
            taken <= 1'b0;
        end else begin
            smp_a <= raw;
            smp_b <= smp_a;
            if (detect)
                taken <= 1'b1;
            else if (!smp_a)
                taken <= 1'b0;
        end
    end

    // R9
    detect_once_chk: assert property (@(posedge clk) disable iff (rst)
        detect |=> !detect);

endmodule

// File: rtl/hra_holdoff.sv
module hra_holdoff #(
    parameter int HOLD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] cfg,
    output logic              busy
);
    logic [HOLD_W-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= cfg;
        else if (busy)
            cnt <= cnt - 1'b1;
    end

    // R6
    holdoff_idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> !busy);

endmodule

// File: rtl/hra_prio.sv
module hra_prio #(
    parameter int N = 3
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_lane
            if (i == 0) begin : g_top
                assign gnt[i] = en & req[i];
            end else begin : g_rest
                assign gnt[i] = en & req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate
endmodule

// File: rtl/hostram_arbiter.sv
module hostram_arbiter #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int NUM_INT = 3,
    parameter int HOLD_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_cs_n,
    input  logic               host_wr_n,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_data,
    input  logic [NUM_INT-1:0] int_req,
    input  logic [HOLD_W-1:0]  holdoff_cfg,
    output logic [NUM_INT-1:0] int_gnt,
    output logic               ram_cs_n,
    output logic               ram_we_n,
    output logic [ADDR_W-2:0]  ram_addr,
    output logic [DATA_W-1:0]  ram_data,
    output logic               ram_data_oe,
    output logic               abuf_en,
    output logic               dlat_en,
    output logic               dlat_dir,
    output logic [DATA_W-1:0]  cmd_reg,
    output logic               cmd_wr,
    output logic               wr_drop
);
    import hra_pkg::*;

    localparam int SEL_BIT = ADDR_W - 1;
    localparam int RAM_AW  = ADDR_W - 1;

    typedef struct packed {
        logic [RAM_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } ram_acc_t;

    wr_phase_e ph;
    ram_acc_t  acc;
    logic      detect, qualifying, hold_busy, int_any, blocked, ram_busy;

    hra_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (host_cs_n),
        .wr_n       (host_wr_n),
        .detect     (detect),
        .qualifying (qualifying)
    );

    hra_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (ph == PH_STROBE),
        .cfg  (holdoff_cfg),
        .busy (hold_busy)
    );

    hra_prio #(.N(NUM_INT)) u_prio (
        .en  (ph == PH_IDLE),
        .req (int_req),
        .gnt (int_gnt)
    );

    assign int_any  = |int_req;
    assign blocked  = (ph != PH_IDLE) | int_any | hold_busy;
    assign ram_busy = in_ram_cycle(ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            acc     <= '0;
            cmd_reg <= '0;
            cmd_wr  <= 1'b0;
            wr_drop <= 1'b0;
        end else begin
            cmd_wr  <= 1'b0;
            wr_drop <= 1'b0;
            case (ph)
                PH_SETUP:  ph <= PH_STROBE;
                PH_STROBE: ph <= PH_IDLE;
                default:   ph <= PH_IDLE;
            endcase
            if (detect) begin
                if (host_addr[SEL_BIT]) begin
                    cmd_reg <= host_data;
                    cmd_wr  <= 1'b1;
                end else if (blocked) begin
                    wr_drop <= 1'b1;
                end else begin
                    ph       <= PH_SETUP;
                    acc.addr <= host_addr[RAM_AW-1:0];
                    acc.data <= host_data;
                end
            end
        end
    end

    assign ram_cs_n    = ~ram_busy;
    assign ram_we_n    = ~(ph == PH_STROBE);
    assign ram_addr    = acc.addr;
    assign ram_data    = acc.data;
    assign ram_data_oe = ram_busy;
    assign abuf_en     = ram_busy | qualifying;
    assign dlat_en     = ram_busy | qualifying;
    assign dlat_dir    = ram_busy;

    // R4
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> !ram_cs_n);

    // R4
    we_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_we_n) |-> $past(!ram_cs_n && ram_we_n));

    // R7
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(int_gnt));

    // R7
    gnt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (|int_gnt) |-> ram_cs_n);

    // R5
    drop_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_cs_n) |-> !wr_drop);

    // R3
    cmd_no_ram_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> !$fell(ram_cs_n) && !wr_drop);

endmodule

// File: tb/tb_hostram_arbiter.sv
`timescale 1ns/1ps
module tb_hostram_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b1, host_wr_n = 1'b1;
    logic [17:0] host_addr = '0;
    logic [15:0] host_data = '0;
    logic [2:0]  int_req = '0;
    logic [5:0]  holdoff_cfg = 6'd4;
    logic [2:0]  int_gnt;
    logic        ram_cs_n, ram_we_n, ram_data_oe, abuf_en, dlat_en, dlat_dir;
    logic [16:0] ram_addr;
    logic [15:0] ram_data, cmd_reg;
    logic        cmd_wr, wr_drop;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hostram_arbiter dut (
        .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_wr_n(host_wr_n),
        .host_addr(host_addr), .host_data(host_data), .int_req(int_req),
        .holdoff_cfg(holdoff_cfg), .int_gnt(int_gnt), .ram_cs_n(ram_cs_n),
        .ram_we_n(ram_we_n), .ram_addr(ram_addr), .ram_data(ram_data),
        .ram_data_oe(ram_data_oe), .abuf_en(abuf_en), .dlat_en(dlat_en),
        .dlat_dir(dlat_dir), .cmd_reg(cmd_reg), .cmd_wr(cmd_wr), .wr_drop(wr_drop)
    );

    typedef struct packed {
        logic        a17;
        logic [16:0] lo;
        logic [15:0] d;
        logic [2:0]  rq;
        logic [1:0]  kind;   // 0 RAM write, 1 command write, 2 dropped
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{1'b0, 17'h00055, 16'h1234, 3'b000, 2'd0},
        '{1'b1, 17'h00000, 16'hBEEF, 3'b000, 2'd1},
        '{1'b1, 17'h00A0A, 16'h5A5A, 3'b010, 2'd1},
        '{1'b0, 17'h00100, 16'h0F0F, 3'b100, 2'd2},
        '{1'b0, 17'h1FFFF, 16'hFFFF, 3'b000, 2'd0},
        '{1'b0, 17'h00003, 16'h7777, 3'b011, 2'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // One host access; strobes released at the falling edge after edge 5 (plus extra).
    task automatic host_acc(input logic a17, input logic [16:0] lo, input logic [15:0] d,
                            input logic [2:0] rq, input logic [1:0] kind, input int extra);
        @(negedge clk);
        host_cs_n = 1'b0; host_wr_n = 1'b0;
        host_addr = {a17, lo}; host_data = d; int_req = rq;
        @(negedge clk);
        @(negedge clk);
        check("R8 abuf_en qualifying", abuf_en, 1);
        check("R8 dlat_en qualifying", dlat_en, 1);
        check("R8 ram_cs_n before decision", ram_cs_n, 1);
        @(negedge clk);
        if (kind == 2'd0) begin
            check("R4 cs_n first cycle", ram_cs_n, 0);
            check("R4 we_n first cycle", ram_we_n, 1);
            check("R4 ram_addr", ram_addr, lo);
            check("R4 ram_data", ram_data, d);
            check("R8 data_oe/dir", {ram_data_oe, dlat_dir}, 2'b11);
        end else if (kind == 2'd1) begin
            check("R3 cmd_wr pulse", cmd_wr, 1);
            check("R3 cmd_reg value", cmd_reg, d);
            check("R3 no RAM cycle", {ram_cs_n, ram_we_n}, 2'b11);
        end else begin
            check("R5 wr_drop pulse", wr_drop, 1);
            check("R5 no RAM cycle", ram_cs_n, 1);
            check("R7 grant lowest", int_gnt, rq & (~rq + 3'd1));
        end
        int_req = '0;
        @(negedge clk);
        if (kind == 2'd0)
            check("R4 cs_n/we_n second cycle", {ram_cs_n, ram_we_n}, 2'b00);
        else if (kind == 2'd1)
            check("R3 cmd_wr one cycle", cmd_wr, 0);
        else
            check("R5 wr_drop one cycle", wr_drop, 0);
        @(negedge clk);
        check("R4 strobes released", {ram_cs_n, ram_we_n}, 2'b11);
        check("R8 enables off", {ram_data_oe, abuf_en, dlat_en, dlat_dir}, 4'b0000);
        for (int k = 0; k < extra; k++) begin
            @(negedge clk);
            check("R9 no repeat", {cmd_wr, wr_drop, ram_cs_n}, 3'b001);
        end
        host_cs_n = 1'b1; host_wr_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 strobes in reset", {ram_cs_n, ram_we_n}, 2'b11);
        rst = 1'b0;
        @(negedge clk);
        check("R1 strobes after reset", {ram_cs_n, ram_we_n}, 2'b11);
        check("R1 enables after reset", {ram_data_oe, abuf_en, dlat_en, dlat_dir}, 4'b0000);
        check("R1 pulses/cmd_reg after reset", {cmd_wr, wr_drop, cmd_reg}, 18'h0);

        // Vector table with generous gaps (holdoff 4)
        for (int i = 0; i < 6; i++) begin
            host_acc(VEC[i].a17, VEC[i].lo, VEC[i].d, VEC[i].rq, VEC[i].kind, 0);
            repeat (8) @(negedge clk);
        end

        // R2: single-edge glitch with bit 17 set, then chip-select only
        @(negedge clk);
        host_cs_n = 1'b0; host_wr_n = 1'b0; host_addr = 18'h20000; host_data = 16'h0001;
        @(negedge clk);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R2 glitch ignored", {cmd_wr, wr_drop, ram_cs_n}, 3'b001);
        end
        host_cs_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R2 cs-only ignored", {cmd_wr, wr_drop, ram_cs_n}, 3'b001);
        end
        host_cs_n = 1'b1;
        check("R2 cmd_reg unchanged", cmd_reg, 16'h5A5A);
        repeat (4) @(negedge clk);

        // R6: back-to-back with holdoff 4 -> drop
        holdoff_cfg = 6'd4;
        host_acc(1'b0, 17'h00011, 16'hAAAA, 3'b000, 2'd0, 0);
        host_acc(1'b0, 17'h00012, 16'hBBBB, 3'b000, 2'd2, 0);
        repeat (10) @(negedge clk);
        // R6: back-to-back with holdoff 3 -> performed
        holdoff_cfg = 6'd3;
        host_acc(1'b0, 17'h00021, 16'hCCCC, 3'b000, 2'd0, 0);
        host_acc(1'b0, 17'h00022, 16'hDDDD, 3'b000, 2'd0, 0);
        repeat (10) @(negedge clk);

        // R9: strobes held long on a command write
        host_acc(1'b1, 17'h0, 16'h4321, 3'b000, 2'd1, 8);
        repeat (4) @(negedge clk);

        // R7: priority when idle, and no grant during a host write
        int_req = 3'b110;
        #1 check("R7 idle grant", int_gnt, 3'b010);
        int_req = 3'b000;
        @(negedge clk);
        host_cs_n = 1'b0; host_wr_n = 1'b0; host_addr = 18'h00044; host_data = 16'h9999;
        repeat (3) @(negedge clk);
        int_req = 3'b001;
        #1 check("R7 no grant in write cycle 1", int_gnt, 3'b000);
        @(negedge clk);
        #1 check("R7 no grant in write cycle 2", int_gnt, 3'b000);
        @(negedge clk);
        #1 check("R7 grant after write", int_gnt, 3'b001);
        host_cs_n = 1'b1; host_wr_n = 1'b1; int_req = 3'b000;
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule